// File: doc/BRIEF.md
# Synchronous Burst Memory Responder

This block acts as the memory side of a synchronous command bus. On each rising clock edge it decodes four active-low command strobes (select, row strobe, column strobe, write enable), a bank number and an address bus. It keeps a small mode register, tracks one open row per bank, and serves read and write bursts from an internal word array. Activation and precharge delays are not modelled. A row opened by an activate command can be used from the next cycle.

A read returns its first word a programmable latency of two or three cycles after the command. After that it returns one word per clock from the open row, with no further address. The mode register sets the burst length (1, 2, 4 or 8 words, or the whole row) and the order of the column addresses (linear or XOR-interleaved). A write takes its first data word on the clock edge after the command, then one word per edge in the same column order. A read or write aimed at a bank with no open row does nothing and raises a one-cycle error flag.

Top module: `sdr_burst_responder`

## Requirements
- R1: After a synchronous reset, `rvalid` and `cmd_err` are low and no bank has an open row. The mode register returns to one-word bursts, linear order and latency 2. The array contents are not cleared.
- R2: A read is decoded when `{cs_n,ras_n,cas_n,we_n}` is 0101. With latency 2, the first word is valid after the second rising edge following the command edge, and `rvalid` is low one cycle before that.
- R3: With latency 3, the first read word is valid after the third rising edge following the command edge.
- R4: A fixed-length burst produces exactly its programmed number of consecutive `rvalid` cycles, and `rvalid` drops in the cycle after the last word.
- R5: In linear order, word i comes from column `(start & ~m) | ((start + i) & m)`, where m = length − 1. The address therefore wraps inside a block aligned to the burst length.
- R6: In interleaved order, word i comes from column `(start & ~m) | ((start ^ i) & m)`.
- R7: A whole-row burst (length code 7) always uses linear order. It wraps from the last column of the row to column 0 and keeps running through no-op cycles.
- R8: A write is decoded when the strobes are 0100. The word on `wdata` at the k-th edge after the command edge (k = 1..length) is stored at the column of burst word k−1.
- R9: A read or write to a bank with no open row raises `cmd_err` for one cycle after the command edge. It starts no burst, produces no read data and changes no stored word.
- R10: An activate (strobes 0011) opens the row `addr[ROW_BITS-1:0]` in bank `ba`. The other banks keep their own open rows.
- R11: A mode-load or activate command stops a running burst. Words already in the latency pipeline still emerge, and no further words follow.
- R12: A mode load (strobes 0000) takes the length code from `addr[2:0]`, the order from `addr[3]` (1 = interleaved) and the latency field from `addr[6:4]` (3 selects latency 3, any other value selects 2). Length codes 0..3 give 1, 2, 4 or 8 words, 7 gives a whole row, and codes 4..6 give one word. All other strobe patterns are no-ops.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Command select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | $clog2(NUM_BANKS) | Bank number |
| addr | input | 7 | Row, start column or mode fields |
| wdata | input | DATA_W | Write burst data |
| rdata | output | DATA_W | Read burst data |
| rvalid | output | 1 | High for each valid read word |
| cmd_err | output | 1 | Read or write to a bank with no open row |

## Verification
Every result has a fixed delay measured in rising edges from the edge that samples the command. `cmd_err` is due one edge later. Read word i is due latency + i edges later. Write word k is taken at edge k. The bench drives each command on a falling edge and then counts falling edges. Read checks fall exactly in the latency + i window, and the bench also checks `rvalid` in the cycle just before the first word and the cycle just after the last. The ignored-access and stop cases are checked by reading back the untouched words, or by watching `rvalid` fall a fixed number of cycles after the stopping command.

// File: rtl/sdr_pkg.sv
// Shared command and mode types for the burst responder.
// Assumes the four strobes are sampled together on the rising edge.
package sdr_pkg;

    typedef enum logic [2:0] {
        CMD_NOP,
        CMD_MODE,
        CMD_ACT,
        CMD_READ,
        CMD_WRITE
    } cmd_e;

    typedef struct packed {
        logic [2:0] len_code;
        logic       interleave;
        logic       lat3;
    } mode_t;

    localparam logic [2:0] LEN_PAGE   = 3'd7;
    localparam mode_t      MODE_RESET = '{len_code: 3'd0, interleave: 1'b0, lat3: 1'b0};

    // Map the strobe pattern {cs,ras,cas,we} to a command; unlisted patterns idle.
    function automatic cmd_e decode_pins(input logic cs_n, input logic ras_n,
                                         input logic cas_n, input logic we_n);
        case ({cs_n, ras_n, cas_n, we_n})
            4'b0000: return CMD_MODE;
            4'b0011: return CMD_ACT;
            4'b0101: return CMD_READ;
            4'b0100: return CMD_WRITE;
            default: return CMD_NOP;
        endcase
    endfunction

endpackage

// File: rtl/sdr_cmd_decode.sv
// Command decoder and mode register.
// Decodes the strobes every cycle; a mode-load command copies the length,
// order and latency fields from the address bus. Assumes a 7-bit field.
module sdr_cmd_decode
    import sdr_pkg::*;
#(
    parameter int MODE_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              ras_n,
    input  logic              cas_n,
    input  logic              we_n,
    input  logic [MODE_W-1:0] mode_bus,
    output cmd_e              cmd,
    output mode_t             mode
);

    // Combinational command decode.
    assign cmd = decode_pins(cs_n, ras_n, cas_n, we_n);

    // Mode register: reset to defaults, reload on a mode command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode <= MODE_RESET;
        end else if (cmd == CMD_MODE) begin
            mode.len_code   <= mode_bus[2:0];
            mode.interleave <= mode_bus[3];
            mode.lat3       <= (mode_bus[6:4] == 3'd3);
        end
    end

endmodule

// File: rtl/sdr_open_rows.sv
// Per-bank open-row table.
// Each bank holds a valid flag and a row number; an activate to a bank
// overwrites its row. Assumes at least two banks.
module sdr_open_rows #(
    parameter int NUM_BANKS = 2,
    parameter int ROW_BITS  = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               act,
    input  logic [BANK_W-1:0]                  act_bank,
    input  logic [ROW_BITS-1:0]                act_row,
    output logic [NUM_BANKS-1:0]               open_vec,
    output logic [NUM_BANKS-1:0][ROW_BITS-1:0] row_tab
);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        logic                open_q;
        logic [ROW_BITS-1:0] row_q;

        // Track this bank's open row.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q <= 1'b0;
                row_q  <= '0;
            end else if (act && (act_bank == BANK_W'(g))) begin
                open_q <= 1'b1;
                row_q  <= act_row;
            end
        end

        assign open_vec[g] = open_q;
        assign row_tab[g]  = row_q;
    end

endmodule

// File: rtl/sdr_burst_seq.sv
// Burst column sequencer.
// Loads a start column and the mode on a read/write, then steps one word
// per clock in linear or XOR order inside a length-aligned block. A
// whole-row burst never ends by itself. A halt stops any burst.
module sdr_burst_seq
    import sdr_pkg::*;
#(
    parameter int COL_BITS = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic                start_wr,
    input  logic [COL_BITS-1:0] start_col,
    input  mode_t               mode,
    input  logic                halt,
    output logic                active,
    output logic                is_wr,
    output logic [COL_BITS-1:0] col
);

    logic [COL_BITS-1:0] base_q;
    logic [COL_BITS-1:0] cnt_q;
    logic [COL_BITS-1:0] mask_q;
    logic                page_q;
    logic                ilv_q;
    logic [COL_BITS-1:0] off;

    // Column mask (length minus one) for a length code.
    function automatic logic [COL_BITS-1:0] len_mask(input logic [2:0] code);
        case (code)
            3'd1:     return COL_BITS'(1);
            3'd2:     return COL_BITS'(3);
            3'd3:     return COL_BITS'(7);
            LEN_PAGE: return '1;
            default:  return '0;
        endcase
    endfunction

    // Burst state: load, halt or advance one word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            is_wr  <= 1'b0;
            base_q <= '0;
            cnt_q  <= '0;
            mask_q <= '0;
            page_q <= 1'b0;
            ilv_q  <= 1'b0;
        end else if (start) begin
            active <= 1'b1;
            is_wr  <= start_wr;
            base_q <= start_col;
            cnt_q  <= '0;
            mask_q <= len_mask(mode.len_code);
            page_q <= (mode.len_code == LEN_PAGE);
            ilv_q  <= mode.interleave && (mode.len_code != LEN_PAGE);
        end else if (halt) begin
            active <= 1'b0;
        end else if (active) begin
            cnt_q <= cnt_q + 1'b1;
            if (!page_q && (cnt_q == mask_q)) begin
                active <= 1'b0;
            end
        end
    end

    // Current column: high bits fixed, low bits stepped within the block.
    always_comb begin
        off = ilv_q ? (base_q ^ cnt_q) : (base_q + cnt_q);
        col = (base_q & ~mask_q) | (off & mask_q);
    end

endmodule

// File: rtl/sdr_read_pipe.sv
// Read latency pipeline.
// Delays each read word through a shift chain and taps it at the
// programmed latency (two or three edges after the command edge).
module sdr_read_pipe #(
    parameter int DATA_W  = 8,
    parameter int MAX_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              lat3,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);

    logic [MAX_LAT-1:0] vq;
    logic [DATA_W-1:0]  dq [MAX_LAT];

    // Valid chain, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) vq <= '0;
        else        vq <= {vq[MAX_LAT-2:0], in_valid};
    end

    // Data chain, first stage.
    always_ff @(posedge clk) dq[0] <= in_data;

    for (genvar s = 1; s < MAX_LAT; s++) begin : g_stage
        // Data chain, later stages.
        always_ff @(posedge clk) dq[s] <= dq[s-1];
    end

    assign out_valid = lat3 ? vq[MAX_LAT-1] : vq[MAX_LAT-2];
    assign out_data  = lat3 ? dq[MAX_LAT-1] : dq[MAX_LAT-2];

endmodule

// File: rtl/sdr_burst_responder.sv
// Synchronous burst memory responder (top).
// Decodes commands, keeps an open row per bank and serves read/write
// bursts from a word array indexed {bank,row,column}. Assumes the address
// bus is at least 7 bits wide and wide enough for a row and a column.
module sdr_burst_responder
    import sdr_pkg::*;
#(
    parameter int NUM_BANKS = 2,
    parameter int ROW_BITS  = 2,
    parameter int COL_BITS  = 3,
    parameter int DATA_W    = 8,
    parameter int ADDR_W    = 7
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cs_n,
    input  logic                         ras_n,
    input  logic                         cas_n,
    input  logic                         we_n,
    input  logic [$clog2(NUM_BANKS)-1:0] ba,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [DATA_W-1:0]            wdata,
    output logic [DATA_W-1:0]            rdata,
    output logic                         rvalid,
    output logic                         cmd_err
);

    localparam int BANK_W = $clog2(NUM_BANKS);
    localparam int IDX_W  = BANK_W + ROW_BITS + COL_BITS;
    localparam int DEPTH  = 1 << IDX_W;

    cmd_e                               cmd;
    mode_t                              mode;
    logic [NUM_BANKS-1:0]               open_vec;
    logic [NUM_BANKS-1:0][ROW_BITS-1:0] row_tab;
    logic                               rw_cmd, rw_go, halt;
    logic                               active, is_wr;
    logic [COL_BITS-1:0]                col;
    logic [BANK_W-1:0]                  bst_bank;
    logic [ROW_BITS-1:0]                bst_row;
    logic [IDX_W-1:0]                   idx;
    logic [DATA_W-1:0]                  mem [DEPTH];

    sdr_cmd_decode #(.MODE_W(ADDR_W)) u_dec (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n),
        .cas_n(cas_n), .we_n(we_n), .mode_bus(addr), .cmd(cmd), .mode(mode)
    );

    sdr_open_rows #(.NUM_BANKS(NUM_BANKS), .ROW_BITS(ROW_BITS)) u_rows (
        .clk(clk), .rst_n(rst_n), .act(cmd == CMD_ACT), .act_bank(ba),
        .act_row(addr[ROW_BITS-1:0]), .open_vec(open_vec), .row_tab(row_tab)
    );

    // Accept a read/write only when its bank has an open row.
    assign rw_cmd = (cmd == CMD_READ) || (cmd == CMD_WRITE);
    assign rw_go  = rw_cmd && open_vec[ba];
    assign halt   = (cmd == CMD_MODE) || (cmd == CMD_ACT);

    sdr_burst_seq #(.COL_BITS(COL_BITS)) u_seq (
        .clk(clk), .rst_n(rst_n), .start(rw_go), .start_wr(cmd == CMD_WRITE),
        .start_col(addr[COL_BITS-1:0]), .mode(mode), .halt(halt),
        .active(active), .is_wr(is_wr), .col(col)
    );

    // Latch the bank and row that the burst works on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bst_bank <= '0;
            bst_row  <= '0;
        end else if (rw_go) begin
            bst_bank <= ba;
            bst_row  <= row_tab[ba];
        end
    end

    // Flag a read/write to a bank with no open row.
    always_ff @(posedge clk) begin
        if (!rst_n) cmd_err <= 1'b0;
        else        cmd_err <= rw_cmd && !open_vec[ba];
    end

    assign idx = {bst_bank, bst_row, col};

    // Store one write-burst word per clock.
    always_ff @(posedge clk) begin
        if (active && is_wr) mem[idx] <= wdata;
    end

    sdr_read_pipe #(.DATA_W(DATA_W), .MAX_LAT(3)) u_pipe (
        .clk(clk), .rst_n(rst_n), .in_valid(active && !is_wr),
        .in_data(mem[idx]), .lat3(mode.lat3),
        .out_valid(rvalid), .out_data(rdata)
    );

endmodule

// File: rtl/sdr_responder_chk.sv
// Property checker for the burst responder, bound into every instance.
// Observes the strobes, the open-row table and the outputs.
module sdr_responder_chk #(
    parameter int NUM_BANKS = 2,
    localparam int BANK_W   = $clog2(NUM_BANKS)
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cs_n,
    input logic                 ras_n,
    input logic                 cas_n,
    input logic                 we_n,
    input logic [BANK_W-1:0]    ba,
    input logic [NUM_BANKS-1:0] open_vec,
    input logic                 rvalid,
    input logic                 cmd_err
);

    logic in_rst_q;

    // Remember that a reset edge has been seen.
    always_ff @(posedge clk) in_rst_q <= !rst_n;

    // Outputs and row table quiet while reset is held.
    always @(negedge clk) begin
        if (in_rst_q && !rst_n) begin
            AST_RESET_STATE: assert (!rvalid && !cmd_err && open_vec == '0); // R1
        end
    end

    AST_ERR_CLOSED_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && ras_n && !cas_n && !open_vec[ba]) |=> cmd_err); // R9

    AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> $past(!cs_n && ras_n && !cas_n)); // R9

    AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && cas_n && we_n) |=> open_vec[$past(ba)]); // R10

endmodule

bind sdr_burst_responder sdr_responder_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
    .we_n(we_n), .ba(ba), .open_vec(open_vec), .rvalid(rvalid), .cmd_err(cmd_err)
);

// File: tb/sim_sdr_burst_responder.sv
`timescale 1ns/1ps
module sim_sdr_burst_responder;

    localparam logic [3:0] C_NOP = 4'b0111;
    localparam logic [3:0] C_MOD = 4'b0000;
    localparam logic [3:0] C_ACT = 4'b0011;
    localparam logic [3:0] C_RD  = 4'b0101;
    localparam logic [3:0] C_WR  = 4'b0100;

    // {words[3:0], len_code[2:0], ilv, lat_field[2:0], bank, col[2:0]}
    localparam logic [14:0] VEC [9] = '{
        {4'd1, 3'd0, 1'b0, 3'd2, 1'b0, 3'd5},
        {4'd2, 3'd1, 1'b0, 3'd2, 1'b0, 3'd3},
        {4'd4, 3'd2, 1'b0, 3'd2, 1'b1, 3'd6},
        {4'd8, 3'd3, 1'b0, 3'd3, 1'b0, 3'd5},
        {4'd4, 3'd2, 1'b1, 3'd2, 1'b1, 3'd5},
        {4'd8, 3'd3, 1'b1, 3'd3, 1'b0, 3'd3},
        {4'd2, 3'd1, 1'b1, 3'd3, 1'b1, 3'd1},
        {4'd4, 3'd2, 1'b0, 3'd3, 1'b0, 3'd2},
        {4'd1, 3'd5, 1'b0, 3'd6, 1'b1, 3'd4}
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
    logic [0:0] ba = '0;
    logic [6:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       rvalid, cmd_err;

    logic [7:0] mdl [2][4][8];
    int         mrow [2];
    int         n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    sdr_burst_responder u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n),
        .we_n(we_n), .ba(ba), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .cmd_err(cmd_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic [3:0] c, input int b, input int a, input int d);
        @(negedge clk);
        {cs_n, ras_n, cas_n, we_n} = c;
        ba    = b[0:0];
        addr  = a[6:0];
        wdata = d[7:0];
    endtask

    function automatic int exp_col(input int start, input int i, input int blc, input int ilv);
        int len, m, off;
        if (blc == 7) return (start + i) & 7;
        len = (blc <= 3) ? (1 << blc) : 1;
        m   = len - 1;
        off = ilv ? (start ^ i) : (start + i);
        return ((start & ~m) | (off & m)) & 7;
    endfunction

    task automatic set_mode(input int blc, input int ilv, input int clf);
        drive(C_MOD, 0, (clf << 4) | (ilv << 3) | blc, 0);
    endtask

    task automatic activate(input int b, input int r);
        drive(C_ACT, b, r, 0);
        mrow[b] = r;
    endtask

    task automatic write_burst(input int b, input int col, input int blc, input int n, input int d0);
        drive(C_WR, b, col, 0);
        for (int i = 0; i < n; i++) begin
            int c, d;
            c = exp_col(col, i, blc, 0);
            d = (d0 + i * 17) & 8'hFF;
            drive(C_NOP, 0, 0, d);
            mdl[b][mrow[b]][c] = d[7:0];
        end
        drive(C_NOP, 0, 0, 0);
    endtask

    task automatic read_run(input int b, input int col, input int blc, input int ilv,
                            input int clf, input int n, input bit check_end,
                            input string tt, input string td);
        int cl, r;
        cl = (clf == 3) ? 3 : 2;
        r  = mrow[b];
        drive(C_RD, b, col, 0);
        for (int idx = 0; idx < cl + n + (check_end ? 1 : 0); idx++) begin
            drive(C_NOP, 0, 0, 0);
            if (idx == cl - 1) begin
                check(rvalid === 1'b0, tt, rvalid, 0);
            end else if (idx >= cl && idx < cl + n) begin
                int c;
                c = exp_col(col, idx - cl, blc, ilv);
                check(rvalid === 1'b1, tt, rvalid, 1);
                check(rdata === mdl[b][r][c], td, rdata, mdl[b][r][c]);
            end else if (idx == cl + n) begin
                check(rvalid === 1'b0, "R4 burst end", rvalid, 0);
            end
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        // R1: reset state
        repeat (4) @(negedge clk);
        check(rvalid === 1'b0 && cmd_err === 1'b0, "R1 in reset", {rvalid, cmd_err}, 0);
        rst_n = 1'b1;
        drive(C_NOP, 0, 0, 0);
        check(rvalid === 1'b0 && cmd_err === 1'b0, "R1 after reset", {rvalid, cmd_err}, 0);

        // R9: read to a bank with no open row
        drive(C_RD, 0, 0, 0);
        drive(C_NOP, 0, 0, 0);
        check(cmd_err === 1'b1, "R9 err raised", cmd_err, 1);
        drive(C_NOP, 0, 0, 0);
        check(cmd_err === 1'b0, "R9 err one cycle", cmd_err, 0);
        for (int k = 0; k < 3; k++) begin
            drive(C_NOP, 0, 0, 0);
            check(rvalid === 1'b0, "R9 no data", rvalid, 0);
        end

        // Fill both banks one word at a time
        set_mode(0, 0, 2);
        activate(0, 1);
        activate(1, 2);
        for (int b = 0; b < 2; b++)
            for (int c = 0; c < 8; c++)
                write_burst(b, c, 0, 1, ((b << 5) | (mrow[b] << 3) | c) ^ 8'h96);

        // Table of read vectors
        for (int i = 0; i < 9; i++) begin
            logic [14:0] v;
            int col, bk, clf, ilv, blc, n;
            string tt, td;
            v   = VEC[i];
            col = int'(v[2:0]);
            bk  = int'(v[3]);
            clf = int'(v[6:4]);
            ilv = int'(v[7]);
            blc = int'(v[10:8]);
            n   = int'(v[14:11]);
            tt  = (clf == 3) ? "R3 latency" : "R2 latency";
            if (ilv != 0)                  td = "R6 interleaved data";
            else if (blc > 3 && blc != 7)  td = "R12 reserved code";
            else                           td = "R5 linear data";
            set_mode(blc, ilv, clf);
            read_run(bk, col, blc, ilv, clf, n, 1'b1, tt, td);
        end

        // R8: four-word write burst then read back
        set_mode(2, 0, 2);
        write_burst(0, 6, 2, 4, 8'h10);
        read_run(0, 4, 2, 0, 2, 4, 1'b1, "R8 read timing", "R8 write order");

        // R7: whole-row burst wraps and runs on; R11: activate stops it
        set_mode(7, 0, 2);
        read_run(1, 6, 7, 0, 2, 12, 1'b0, "R7 row burst", "R7 row wrap");
        activate(1, mrow[1]);
        drive(C_NOP, 0, 0, 0);
        drive(C_NOP, 0, 0, 0);
        drive(C_NOP, 0, 0, 0);
        check(rvalid === 1'b0, "R11 burst stopped", rvalid, 0);

        // R10: independent open rows per bank
        set_mode(0, 0, 2);
        activate(1, 3);
        write_burst(1, 0, 0, 1, 8'hC3);
        read_run(0, 0, 0, 0, 2, 1, 1'b1, "R10 timing", "R10 bank0 row kept");
        read_run(1, 0, 0, 0, 2, 1, 1'b1, "R10 timing", "R10 new row");
        activate(1, 2);
        read_run(1, 0, 0, 0, 2, 1, 1'b1, "R10 timing", "R10 old row intact");

        // R1 and R9: reset closes rows, write to closed bank ignored
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(rvalid === 1'b0 && cmd_err === 1'b0, "R1 second reset", {rvalid, cmd_err}, 0);
        rst_n = 1'b1;
        drive(C_WR, 0, 0, 0);
        drive(C_NOP, 0, 0, 8'hEE);
        check(cmd_err === 1'b1, "R9 write err", cmd_err, 1);
        activate(0, 1);
        read_run(0, 0, 0, 0, 2, 1, 1'b1, "R1 reset latency", "R9 word unchanged");

        finish_run();
    end

endmodule